// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Per-Operation Condition Rules

This block is the add/subtract datapath of a RISC integer pipeline. It takes a second source value and a first operand. The first operand is either a register value or a 16-bit immediate, chosen by the low opcode bit. A two-bit operation select picks one of four operations: unsigned add, signed add, unsigned subtract or signed subtract. The block returns a wrapped 32-bit result and a single condition-code bit.

The rule that forms the condition code depends on the operation. Unsigned add reports the carry out. Signed add reports whether its result is negative; it does not report overflow. Both subtracts report "first operand less than second", unsigned or two's-complement as the operation says. A subtract always computes the first operand minus the second source.

The arithmetic is combinational. A parameter adds a registered output stage with a one-clock latency. Register-file access and forwarding belong to the surrounding pipeline.

Top module: `int_addsub_unit`

## Requirements
- R1: When `imm_sel` is 1, operand A is `imm` sign-extended from 16 to 32 bits (bit 15 copied into bits 31..16). When `imm_sel` is 0, operand A is `src1`.
- R2: With `op_sel` = 2'b00 (unsigned add), `result` is A + `src2` modulo 2^32 and `cc` is the carry out of bit 31.
- R3: With `op_sel` = 2'b01 (signed add), `result` is A + `src2` modulo 2^32 and `cc` equals `result[31]`, whether or not the sum overflowed.
- R4: With `op_sel` = 2'b10 or 2'b11, `result` is A − `src2` modulo 2^32. The operand order is never reversed.
- R5: With `op_sel` = 2'b10 (unsigned subtract), `cc` is 1 exactly when A < `src2` as unsigned numbers.
- R6: With `op_sel` = 2'b11 (signed subtract), `cc` is 1 exactly when A < `src2` as two's-complement numbers, including when the difference overflows.
- R7: The result wraps in every operation. No trap or other output reports overflow.
- R8: With `REG_OUT` = 1 (the default), `result` and `cc` appear on the clock edge after the inputs are applied. While `rst_n` is low they are held at 0. With `REG_OUT` = 0 the outputs follow the inputs combinationally.
- R9: The unselected first-operand source has no effect on the outputs: `imm` when `imm_sel` = 0, and `src1` when `imm_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_sel | input | 2 | Operation: 00 addu, 01 adds, 10 subu, 11 subs |
| imm_sel | input | 1 | Low opcode bit: 1 selects the immediate as operand A |
| src1 | input | 32 | Register value for operand A |
| imm | input | 16 | Immediate for operand A, sign-extended |
| src2 | input | 32 | Second operand |
| result | output | 32 | Wrapped sum or difference |
| cc | output | 1 | Condition-code bit, formed by the rule of the operation |

## Verification
The bench separates signed add's sign rule from an overflow rule and from a carry rule:
- −1 + −1 must give a set bit, although it does not overflow.
- 0x80000000 + 0x80000000 must give a clear bit, although it overflows.

A unit that reused carry or overflow would flip one of these.

For the subtracts, the bench checks:
- operands in both orders, which catches a swapped subtrahend;
- equal operands, where a less-or-equal compare would wrongly set the bit;
- −1 against 1, where signed and unsigned comparisons disagree;
- overflowing signed differences, where a plain sign test gives the wrong answer.

Immediates with bit 15 set catch zero-extension. Vectors that change only the unselected operand source show any leakage of that source into the result.

// File: rtl/int_addsub_pkg.sv
package int_addsub_pkg;

   typedef enum logic [1:0] {
      OP_ADDU = 2'b00,
      OP_ADDS = 2'b01,
      OP_SUBU = 2'b10,
      OP_SUBS = 2'b11
   } addsub_op_e;

   function automatic logic op_is_sub(input addsub_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/addsub_opnd_mux.sv
module addsub_opnd_mux #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic              imm_sel,
   input  logic [DATA_W-1:0] src1,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] opnd_a
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (EXT_W > 0) begin : g_sext
         assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
      end else begin : g_full
         assign imm_ext = imm;
      end
   endgenerate

   assign opnd_a = imm_sel ? imm_ext : src1;

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
   parameter int DATA_W = 32
) (
   input  logic              do_sub,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   assign b_eff = do_sub ? ~opnd_b : opnd_b;
   assign wide  = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
   assign sum   = wide[MSB:0];
   assign carry = wide[DATA_W];
   assign ovf   = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);

endmodule

// File: rtl/addsub_cc_rule.sv
module addsub_cc_rule
   import int_addsub_pkg::*;
(
   input  addsub_op_e op,
   input  logic       sum_msb,
   input  logic       carry,
   input  logic       ovf,
   output logic       cc
);
   always_comb begin
      unique case (op)
         OP_ADDU: cc = carry;
         OP_ADDS: cc = sum_msb;
         OP_SUBU: cc = ~carry;
         OP_SUBS: cc = sum_msb ^ ovf;
         default: cc = 1'b0;
      endcase
   end
endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
   import int_addsub_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_sel,
   input  logic              imm_sel,
   input  logic [DATA_W-1:0] src1,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] src2,
   output logic [DATA_W-1:0] result,
   output logic              cc
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2)          begin : g_bad_w   $error("DATA_W must be at least 2"); end
      if (IMM_W < 1 || IMM_W > DATA_W)
                               begin : g_bad_imm $error("IMM_W must lie in 1..DATA_W"); end
      if (REG_OUT != 0 && REG_OUT != 1)
                               begin : g_bad_reg $error("REG_OUT must be 0 or 1"); end
   endgenerate

   addsub_op_e        op;
   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] sum_c;
   logic              carry_c;
   logic              ovf_c;
   logic              cc_c;

   assign op = addsub_op_e'(op_sel);

   addsub_opnd_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
      .imm_sel (imm_sel),
      .src1    (src1),
      .imm     (imm),
      .opnd_a  (opnd_a)
   );

   addsub_core #(.DATA_W(DATA_W)) u_core (
      .do_sub (op_is_sub(op)),
      .opnd_a (opnd_a),
      .opnd_b (src2),
      .sum    (sum_c),
      .carry  (carry_c),
      .ovf    (ovf_c)
   );

   addsub_cc_rule u_cc (
      .op      (op),
      .sum_msb (sum_c[MSB]),
      .carry   (carry_c),
      .ovf     (ovf_c),
      .cc      (cc_c)
   );

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               result <= '0;
               cc     <= 1'b0;
            end else begin
               result <= sum_c;
               cc     <= cc_c;
            end
         end
      end else begin : g_comb
         assign result = sum_c;
         assign cc     = cc_c;
      end
   endgenerate

endmodule

// File: rtl/int_addsub_unit_chk.sv
module int_addsub_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int REG_OUT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        op_sel,
   input logic              imm_sel,
   input logic [DATA_W-1:0] src1,
   input logic [IMM_W-1:0]  imm,
   input logic [DATA_W-1:0] src2,
   input logic [DATA_W-1:0] result,
   input logic              cc
);
   localparam int MSB = DATA_W - 1;

   logic [1:0]        p_op;
   logic              p_isel;
   logic [DATA_W-1:0] p_s1;
   logic [IMM_W-1:0]  p_imm;
   logic [DATA_W-1:0] p_s2;
   logic              vld;

   generate
      if (REG_OUT == 1) begin : g_lag
         always_ff @(posedge clk) begin
            p_op   <= op_sel;
            p_isel <= imm_sel;
            p_s1   <= src1;
            p_imm  <= imm;
            p_s2   <= src2;
            vld    <= rst_n;
         end
      end else begin : g_now
         assign p_op   = op_sel;
         assign p_isel = imm_sel;
         assign p_s1   = src1;
         assign p_imm  = imm;
         assign p_s2   = src2;
         assign vld    = 1'b1;
      end
   endgenerate

   logic [DATA_W-1:0] ea;
   logic [DATA_W:0]   e_add;
   logic [DATA_W-1:0] e_dif;

   assign ea    = p_isel ? DATA_W'($signed(p_imm)) : p_s1;
   assign e_add = {1'b0, ea} + {1'b0, p_s2};
   assign e_dif = ea - p_s2;

   AST_OPERAND_A: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_op == 2'b00) |-> result == e_add[MSB:0]);                   // R1
   AST_ADDU_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_op == 2'b00) |-> cc == e_add[DATA_W]);                      // R2
   AST_ADDS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_op == 2'b01) |-> cc == result[MSB]);                        // R3
   AST_SUB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_op[1]) |-> result == e_dif);                                // R4
   AST_SUBU_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_op == 2'b10) |-> cc == (ea < p_s2));                        // R5
   AST_SUBS_LESS: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_op == 2'b11) |-> cc == ($signed(ea) < $signed(p_s2)));      // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !p_op[1]) |-> result == e_add[MSB:0]);                        // R7

endmodule

bind int_addsub_unit int_addsub_unit_chk #(
   .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .imm_sel(imm_sel),
   .src1(src1), .imm(imm), .src2(src2), .result(result), .cc(cc)
);

// File: tb/int_addsub_unit_tb_top.sv
module int_addsub_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_sel = '0;
   logic          imm_sel = 1'b0;
   logic [DW-1:0] src1 = '0;
   logic [IW-1:0] imm = '0;
   logic [DW-1:0] src2 = '0;
   logic [DW-1:0] result;
   logic          cc;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;

   typedef struct {
      logic [DW-1:0] res;
      logic          cc;
      int            cyc;
      string         req;
   } item_t;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   int_addsub_unit #(.DATA_W(DW), .IMM_W(IW), .REG_OUT(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .imm_sel(imm_sel),
      .src1(src1), .imm(imm), .src2(src2), .result(result), .cc(cc)
   );

   task automatic model(input logic [1:0] op, input logic isel,
                        input logic [DW-1:0] s1, input logic [IW-1:0] im,
                        input logic [DW-1:0] s2,
                        output logic [DW-1:0] r, output logic c);
      logic [DW-1:0] a;
      logic [DW:0]   w;
      a = isel ? {{(DW-IW){im[IW-1]}}, im} : s1;
      case (op)
         2'b00: begin w = {1'b0, a} + {1'b0, s2}; r = w[DW-1:0]; c = w[DW]; end
         2'b01: begin r = a + s2; c = r[DW-1]; end
         2'b10: begin r = a - s2; c = (a < s2); end
         default: begin r = a - s2; c = ($signed(a) < $signed(s2)); end
      endcase
   endtask

   task automatic drive(input logic [1:0] op, input logic isel,
                        input logic [DW-1:0] s1, input logic [IW-1:0] im,
                        input logic [DW-1:0] s2, input string req);
      item_t it;
      @(negedge clk);
      op_sel = op; imm_sel = isel; src1 = s1; imm = im; src2 = s2;
      model(op, isel, s1, im, s2, it.res, it.cc);
      it.cyc = cyc;
      it.req = req;
      sb.push_back(it);
   endtask

   always @(negedge clk) begin
      if (rst_n && sb.size() > 0 && sb[0].cyc < cyc) begin
         item_t it;
         it = sb.pop_front();
         n_checks++;
         if (result !== it.res || cc !== it.cc) begin
            n_fails++;
            $display("FAIL %s: result=%h cc=%b expected result=%h cc=%b",
                     it.req, result, cc, it.res, it.cc);
         end
      end
   end

   bit finished = 0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R8: reset holds outputs at zero even with active inputs
      op_sel = 2'b00; src1 = 32'hFFFF_FFFF; src2 = 32'h1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (result !== '0 || cc !== 1'b0) begin
         n_fails++;
         $display("FAIL R8: reset result=%h cc=%b expected result=0 cc=0", result, cc);
      end
      rst_n = 1'b1;

      // R2 carry out and wrap (R7)
      drive(2'b00, 0, 32'hFFFF_FFFF, 16'h0, 32'h1,          "R2");
      drive(2'b00, 0, 32'h1234_0000, 16'h0, 32'h0000_5678,  "R2");
      // R3 sign rule, not overflow, not carry
      drive(2'b01, 0, 32'hFFFF_FFFF, 16'h0, 32'hFFFF_FFFF,  "R3");
      drive(2'b01, 0, 32'h8000_0000, 16'h0, 32'h8000_0000,  "R3");
      drive(2'b01, 0, 32'h7FFF_FFFF, 16'h0, 32'h1,          "R3");
      drive(2'b01, 0, 32'd5,         16'h0, 32'd3,          "R3");
      // R4 / R5 operand order and borrow
      drive(2'b10, 0, 32'd3,         16'h0, 32'd5,          "R5");
      drive(2'b10, 0, 32'd5,         16'h0, 32'd3,          "R4");
      drive(2'b10, 0, 32'd7,         16'h0, 32'd7,          "R5");
      // R6 signed less-than incl. overflow
      drive(2'b11, 0, 32'hFFFF_FFFF, 16'h0, 32'h1,          "R6");
      drive(2'b11, 0, 32'h8000_0000, 16'h0, 32'h1,          "R6");
      drive(2'b11, 0, 32'h7FFF_FFFF, 16'h0, 32'hFFFF_FFFF,  "R6");
      drive(2'b11, 0, 32'd9,         16'h0, 32'd9,          "R6");
      // R1 immediate sign extension
      drive(2'b00, 1, 32'hDEAD_BEEF, 16'h8000, 32'h0,       "R1");
      drive(2'b10, 1, 32'h0,         16'h7FFF, 32'h1,       "R1");
      drive(2'b11, 1, 32'h0,         16'hFFFF, 32'h0,       "R1");
      // R9 unselected source ignored: pairs must give identical outputs
      drive(2'b00, 1, 32'h0000_0000, 16'h0010, 32'h20,      "R9");
      drive(2'b00, 1, 32'hFFFF_FFFF, 16'h0010, 32'h20,      "R9");
      drive(2'b10, 0, 32'h100,       16'h0000, 32'h1,       "R9");
      drive(2'b10, 0, 32'h100,       16'hFFFF, 32'h1,       "R9");
      // R8 back-to-back one-cycle latency, mixed patterns (R7 wrap)
      for (int i = 0; i < 300; i++) begin
         logic [1:0] op;
         string tag;
         op = 2'($urandom);
         case (op)
            2'b00: tag = "R2";
            2'b01: tag = "R3";
            2'b10: tag = "R5";
            default: tag = "R6";
         endcase
         drive(op, 1'($urandom), $urandom, 16'($urandom), $urandom, tag);
      end

      @(negedge clk);
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule